// File: doc/BRIEF.md
# Dual-Line Level/Edge GPIO Bank

A bank of up to 32 general-purpose pins behind a 32-bit register port. Each pin is an input or a driven output. As an input, a pin can raise an interrupt on a rising edge, a falling edge, a held high level or a held low level. One detected event sets the pin's bit in two separate status sets at once. Each set has its own enable mask and its own interrupt line, so two processors can share the bank and each acknowledge only its own copy.

Output data, both enable masks and the wake enable each have write-ones-to-set and write-ones-to-clear alias offsets. A read of an alias offset returns the register behind it. A single-cycle wake pulse goes out on an event only when the configuration word enables wake and selects an idle mode. A configuration write can also return the bank to its reset state. Byte and halfword writes are merged into the addressed word. The two debounce registers only hold values.

Top module: `gpb_bank`

## Requirements
- R1: After reset, output enable (0x34) reads all ones. Control (0x30) reads 2. Configuration, status, enables, wake enable and the four detect registers read 0. Offset 0x14 always reads 1, offset 0x00 reads the REVISION parameter, and any unlisted offset reads 0. Writes to 0x00, 0x14 and 0x38 have no effect.
- R2: An input pin that goes high raises an event if its rising bit (0x48) or its level-high bit (0x44) is set. An input pin that goes low raises an event if its falling bit (0x4C) or its level-low bit (0x40) is set. An event sets the pin's bit in status set A (0x18) and in status set B (0x28).
- R3: A pin whose output-enable bit is 0, which makes it an output, raises no event.
- R4: irq_a is high exactly when status A AND enable A (0x1C) is nonzero. irq_b is high exactly when status B AND enable B (0x2C) is nonzero.
- R5: Writing ones to a status set clears those bits. Only such a write removes bits. If the write cleared any bit, the set is then ORed with (input pins) AND ((pin high AND level-high) OR (pin low AND level-low)).
- R6: A write to output enable, level-low or level-high ORs the level condition of R5 into both status sets, using the newly written values.
- R7: Offsets 0x60/0x64 clear/set enable A, 0x70/0x74 clear/set enable B, 0x80/0x84 clear/set wake enable (0x20), and 0x90/0x94 clear/set output data (0x3C). Each alias offset reads as the register behind it.
- R8: pin_drive equals the inverted output enable. pin_out equals output data on driven pins and 0 elsewhere.
- R9: wake_pulse goes high for one cycle after an event on a pin whose wake-enable bit is set. This happens only if configuration bit 2 is set and configuration bits [4:3] are nonzero.
- R10: A configuration write with bit 1 set restores the R1 values of every register except output data. Configuration stores the written value AND 0x1D. Control keeps its low 3 bits.
- R11: bus_size selects the access width: 0 is a byte, 1 is a halfword, 2 is a word. A byte or halfword write takes its data from the low bits of bus_wdata and places it in the lane at bus_addr[1:0]. In ordinary registers the other lanes keep their contents. In status and alias offsets the other lanes count as zero. bus_rdata is the addressed word shifted right by 8 × bus_addr[1:0].
- R12: Debounce enable (0x50, 32 bits) and debounce time (0x54, 8 bits) read back the stored value and affect nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | LINES | Sampled pin levels |
| pin_out | output | LINES | Pin output values |
| pin_drive | output | LINES | 1 where the pin is driven |
| irq_a | output | 1 | Interrupt of status set A |
| irq_b | output | 1 | Interrupt of status set B |
| wake_pulse | output | 1 | Single-cycle wake request |

## Verification
The detector is tried with three pin patterns:
- A rising edge on a pin with only its rising bit set, which separates event capture from level handling.
- A rise and then a fall on a pin with only its falling bit set, which shows that the edge direction is decoded.
- A pin held at its active level while status is cleared and output enable or the level registers are rewritten, which separates a one-shot edge event from a re-applied level condition.

A rising edge on an output pin checks the direction gate. A set-A clear that leaves set B untouched shows that the two sets are independent. Wake is tried with three configuration and wake-enable mixes: wake bit set with no idle mode, both enabled, and wake enable cleared. Only the case with both enabled may produce a pulse. Narrow writes go to a plain register, an alias and a status set, and their results separate lane merging from zero-filled lanes.

// File: rtl/gpb_pkg.sv
`timescale 1ns/1ps
package gpb_pkg;
   localparam int unsigned DW    = 32;
   localparam int unsigned AW    = 8;
   localparam int unsigned NSETS = 2;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   localparam logic [AW-1:0] OFS_REV   = 8'h00;
   localparam logic [AW-1:0] OFS_CFG   = 8'h10;
   localparam logic [AW-1:0] OFS_STS   = 8'h14;
   localparam logic [AW-1:0] OFS_WEN   = 8'h20;
   localparam logic [AW-1:0] OFS_CTRL  = 8'h30;
   localparam logic [AW-1:0] OFS_OE    = 8'h34;
   localparam logic [AW-1:0] OFS_DIN   = 8'h38;
   localparam logic [AW-1:0] OFS_DOUT  = 8'h3C;
   localparam logic [AW-1:0] OFS_LO    = 8'h40;
   localparam logic [AW-1:0] OFS_HI    = 8'h44;
   localparam logic [AW-1:0] OFS_RISE  = 8'h48;
   localparam logic [AW-1:0] OFS_FALL  = 8'h4C;
   localparam logic [AW-1:0] OFS_DBEN  = 8'h50;
   localparam logic [AW-1:0] OFS_DBT   = 8'h54;
   localparam logic [AW-1:0] OFS_WCLR  = 8'h80;
   localparam logic [AW-1:0] OFS_WSET  = 8'h84;
   localparam logic [AW-1:0] OFS_DCLR  = 8'h90;
   localparam logic [AW-1:0] OFS_DSET  = 8'h94;

   // per status set offsets: index 0 is set A, index 1 is set B
   localparam logic [AW-1:0] OFS_STAT  [NSETS] = '{8'h18, 8'h28};
   localparam logic [AW-1:0] OFS_EN    [NSETS] = '{8'h1C, 8'h2C};
   localparam logic [AW-1:0] OFS_ENCLR [NSETS] = '{8'h60, 8'h70};
   localparam logic [AW-1:0] OFS_ENSET [NSETS] = '{8'h64, 8'h74};

   localparam logic [4:0] CFG_KEEP = 5'h1D;
   localparam logic [2:0] CTRL_RST = 3'd2;
endpackage

// File: rtl/gpb_lane.sv
`timescale 1ns/1ps
module gpb_lane import gpb_pkg::*; (
   input  logic [1:0]    size,
   input  logic [1:0]    lane,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] cur,
   output logic [DW-1:0] raw,
   output logic [DW-1:0] merged
);
   logic [4:0]    sh;
   logic [DW-1:0] lmask;

   always_comb begin
      sh = {lane, 3'b000};
      case (size)
         SZ_BYTE: lmask = DW'(32'h0000_00FF) << sh;
         SZ_HALF: lmask = DW'(32'h0000_FFFF) << sh;
         default: lmask = '1;
      endcase
      if (size == SZ_BYTE || size == SZ_HALF)
         raw = (wdata << sh) & lmask;
      else
         raw = wdata;
      merged = (cur & ~lmask) | raw;
   end
endmodule

// File: rtl/gpb_detect.sv
`timescale 1ns/1ps
module gpb_detect #(
   parameter int unsigned LINES  = 32,
   parameter int unsigned STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pin_in,
   input  logic [LINES-1:0] is_input,
   input  logic [LINES-1:0] rise_en,
   input  logic [LINES-1:0] fall_en,
   input  logic [LINES-1:0] lo_en,
   input  logic [LINES-1:0] hi_en,
   output logic [LINES-1:0] level,
   output logic [LINES-1:0] evt
);
   logic [STAGES-1:0][LINES-1:0] chain_q;
   logic [LINES-1:0]             prev_q;

   if (STAGES < 1) begin : g_bad_stages
      $error("gpb_detect: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= pin_in;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], pin_in};
      end
   end

   assign level = chain_q[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign evt = is_input & ((level & ~prev_q & (rise_en | hi_en)) |
                            (~level & prev_q & (fall_en | lo_en)));
endmodule

// File: rtl/gpb_irq_set.sv
`timescale 1ns/1ps
module gpb_irq_set #(
   parameter int unsigned LINES = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [LINES-1:0] evt,
   input  logic [LINES-1:0] lvl_term,
   input  logic             reeval,
   input  logic             clr_wr,
   input  logic             en_wr,
   input  logic             en_set,
   input  logic             en_clr,
   input  logic [LINES-1:0] wfull,
   input  logic [LINES-1:0] wraw,
   output logic [LINES-1:0] stat,
   output logic [LINES-1:0] en,
   output logic             irq
);
   logic [LINES-1:0] stat_q, stat_n, en_q, en_n;

   always_comb begin
      stat_n = stat_q;
      if (clr_wr) begin
         stat_n = stat_q & ~wraw;
         if (|(stat_q & wraw)) stat_n = stat_n | lvl_term;
      end
      if (reeval) stat_n = stat_n | lvl_term;
      stat_n = stat_n | evt;

      en_n = en_q;
      if (en_wr)  en_n = wfull;
      if (en_set) en_n = en_q | wraw;
      if (en_clr) en_n = en_q & ~wraw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         en_q   <= '0;
      end else if (soft_rst) begin
         stat_q <= '0;
         en_q   <= '0;
      end else begin
         stat_q <= stat_n;
         en_q   <= en_n;
      end
   end

   assign stat = stat_q;
   assign en   = en_q;
   assign irq  = |(stat_q & en_q);

   // R5
   stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_wr || soft_rst) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
   // R7
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_set && !soft_rst) |=> ((en_q & $past(wraw)) == $past(wraw)));
   // R7
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_clr && !soft_rst) |=> ((en_q & $past(wraw)) == '0));
endmodule

// File: rtl/gpb_bank.sv
`timescale 1ns/1ps
module gpb_bank import gpb_pkg::*; #(
   parameter int unsigned LINES       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  REVISION    = 8'h31
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [1:0]       bus_size,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [LINES-1:0] pin_in,
   output logic [LINES-1:0] pin_out,
   output logic [LINES-1:0] pin_drive,
   output logic             irq_a,
   output logic             irq_b,
   output logic             wake_pulse
);
   if (LINES < 1 || LINES > DW) begin : g_bad_lines
      $error("gpb_bank: LINES must lie in 1..32");
   end

   logic [AW-1:0]    wa;
   logic [4:0]       rsh;
   logic [DW-1:0]    rd_word, raw, merged;
   logic [LINES-1:0] mraw, mfull;

   logic [4:0]       cfg_q;
   logic [2:0]       ctrl_q;
   logic [7:0]       dbt_q;
   logic [LINES-1:0] oe_q, dout_q, lo_q, hi_q, rise_q, fall_q, wen_q, dben_q;
   logic [LINES-1:0] oe_n, lo_n, hi_n;
   logic [LINES-1:0] level, evt, lvl_term;
   logic             wake_q;

   logic [LINES-1:0] st  [NSETS];
   logic [LINES-1:0] en  [NSETS];
   logic             irq [NSETS];

   logic wr_cfg, wr_wen, wr_wclr, wr_wset, wr_ctrl, wr_oe, wr_dout, wr_dclr, wr_dset;
   logic wr_lo, wr_hi, wr_rise, wr_fall, wr_dben, wr_dbt, soft_rst, reeval;

   assign wa  = {bus_addr[AW-1:2], 2'b00};
   assign rsh = {bus_addr[1:0], 3'b000};

   // read mux, also the current word for narrow-write merging
   always_comb begin
      rd_word = '0;
      case (wa)
         OFS_REV:                                  rd_word = DW'(REVISION);
         OFS_CFG:                                  rd_word = DW'(cfg_q);
         OFS_STS:                                  rd_word = DW'(1);
         OFS_STAT[0]:                              rd_word = DW'(st[0]);
         OFS_EN[0], OFS_ENCLR[0], OFS_ENSET[0]:    rd_word = DW'(en[0]);
         OFS_STAT[1]:                              rd_word = DW'(st[1]);
         OFS_EN[1], OFS_ENCLR[1], OFS_ENSET[1]:    rd_word = DW'(en[1]);
         OFS_WEN, OFS_WCLR, OFS_WSET:              rd_word = DW'(wen_q);
         OFS_CTRL:                                 rd_word = DW'(ctrl_q);
         OFS_OE:                                   rd_word = DW'(oe_q);
         OFS_DIN:                                  rd_word = DW'(level);
         OFS_DOUT, OFS_DCLR, OFS_DSET:             rd_word = DW'(dout_q);
         OFS_LO:                                   rd_word = DW'(lo_q);
         OFS_HI:                                   rd_word = DW'(hi_q);
         OFS_RISE:                                 rd_word = DW'(rise_q);
         OFS_FALL:                                 rd_word = DW'(fall_q);
         OFS_DBEN:                                 rd_word = DW'(dben_q);
         OFS_DBT:                                  rd_word = DW'(dbt_q);
         default:                                  rd_word = '0;
      endcase
   end

   assign bus_rdata = rd_word >> rsh;

   gpb_lane i_lane (
      .size   (bus_size),
      .lane   (bus_addr[1:0]),
      .wdata  (bus_wdata),
      .cur    (rd_word),
      .raw    (raw),
      .merged (merged)
   );

   assign mraw  = raw[LINES-1:0];
   assign mfull = merged[LINES-1:0];

   assign wr_cfg   = bus_wr && (wa == OFS_CFG);
   assign wr_wen   = bus_wr && (wa == OFS_WEN);
   assign wr_wclr  = bus_wr && (wa == OFS_WCLR);
   assign wr_wset  = bus_wr && (wa == OFS_WSET);
   assign wr_ctrl  = bus_wr && (wa == OFS_CTRL);
   assign wr_oe    = bus_wr && (wa == OFS_OE);
   assign wr_dout  = bus_wr && (wa == OFS_DOUT);
   assign wr_dclr  = bus_wr && (wa == OFS_DCLR);
   assign wr_dset  = bus_wr && (wa == OFS_DSET);
   assign wr_lo    = bus_wr && (wa == OFS_LO);
   assign wr_hi    = bus_wr && (wa == OFS_HI);
   assign wr_rise  = bus_wr && (wa == OFS_RISE);
   assign wr_fall  = bus_wr && (wa == OFS_FALL);
   assign wr_dben  = bus_wr && (wa == OFS_DBEN);
   assign wr_dbt   = bus_wr && (wa == OFS_DBT);
   assign soft_rst = wr_cfg && merged[1];
   assign reeval   = wr_oe || wr_lo || wr_hi;

   // level condition from the values being written this cycle
   assign oe_n     = wr_oe ? mfull : oe_q;
   assign lo_n     = wr_lo ? mfull : lo_q;
   assign hi_n     = wr_hi ? mfull : hi_q;
   assign lvl_term = oe_n & ((level & hi_n) | (~level & lo_n));

   gpb_detect #(.LINES(LINES), .STAGES(SYNC_STAGES)) i_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_in   (pin_in),
      .is_input (oe_q),
      .rise_en  (rise_q),
      .fall_en  (fall_q),
      .lo_en    (lo_q),
      .hi_en    (hi_q),
      .level    (level),
      .evt      (evt)
   );

   for (genvar g = 0; g < NSETS; g++) begin : g_set
      gpb_irq_set #(.LINES(LINES)) i_set (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .evt      (evt),
         .lvl_term (lvl_term),
         .reeval   (reeval),
         .clr_wr   (bus_wr && (wa == OFS_STAT[g])),
         .en_wr    (bus_wr && (wa == OFS_EN[g])),
         .en_set   (bus_wr && (wa == OFS_ENSET[g])),
         .en_clr   (bus_wr && (wa == OFS_ENCLR[g])),
         .wfull    (mfull),
         .wraw     (mraw),
         .stat     (st[g]),
         .en       (en[g]),
         .irq      (irq[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ctrl_q <= CTRL_RST;
         oe_q   <= '1;
         lo_q   <= '0;
         hi_q   <= '0;
         rise_q <= '0;
         fall_q <= '0;
         wen_q  <= '0;
         dben_q <= '0;
         dbt_q  <= '0;
         wake_q <= 1'b0;
      end else begin
         wake_q <= !soft_rst && cfg_q[2] && (cfg_q[4:3] != 2'b00) && (|(evt & wen_q));
         if (soft_rst) begin
            cfg_q  <= merged[4:0] & CFG_KEEP;
            ctrl_q <= CTRL_RST;
            oe_q   <= '1;
            lo_q   <= '0;
            hi_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
            wen_q  <= '0;
            dben_q <= '0;
            dbt_q  <= '0;
         end else begin
            if (wr_cfg)  cfg_q  <= merged[4:0] & CFG_KEEP;
            if (wr_ctrl) ctrl_q <= merged[2:0];
            oe_q <= oe_n;
            lo_q <= lo_n;
            hi_q <= hi_n;
            if (wr_rise) rise_q <= mfull;
            if (wr_fall) fall_q <= mfull;
            if (wr_wen)  wen_q  <= mfull;
            if (wr_wset) wen_q  <= wen_q | mraw;
            if (wr_wclr) wen_q  <= wen_q & ~mraw;
            if (wr_dben) dben_q <= mfull;
            if (wr_dbt)  dbt_q  <= merged[7:0];
         end
      end
   end

   // output data survives a soft reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (wr_dout) dout_q <= mfull;
      else if (wr_dset) dout_q <= dout_q | mraw;
      else if (wr_dclr) dout_q <= dout_q & ~mraw;
   end

   assign pin_drive  = ~oe_q;
   assign pin_out    = dout_q & ~oe_q;
   assign irq_a      = irq[0];
   assign irq_b      = irq[1];
   assign wake_pulse = wake_q;

   // R9
   wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[2] || cfg_q[4:3] == 2'b00) |=> !wake_pulse);
   // R10
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (oe_q == '1 && ctrl_q == CTRL_RST && st[0] == '0 && st[1] == '0));
endmodule

// File: tb/test_gpb_bank.sv
`timescale 1ns/1ps
module test_gpb_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_drive;
   logic        irq_a, irq_b, wake_pulse;

   int checks = 0;
   int errors = 0;
   int wake_cnt = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpb_bank i_gpb_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_drive(pin_drive),
      .irq_a(irq_a), .irq_b(irq_b), .wake_pulse(wake_pulse)
   );

   always @(posedge clk) if (rst_n && wake_pulse) wake_cnt++;

   typedef struct packed {
      logic        wr;
      logic [7:0]  wa;
      logic [1:0]  sz;
      logic [31:0] wd;
      logic [7:0]  ra;
      logic [31:0] ex;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 8'h1C, 2'd2, 32'h0000_00F0, 8'h1C, 32'h0000_00F0, 4'd7},  // R7 enable A full write
      '{1'b1, 8'h64, 2'd2, 32'h0000_0F00, 8'h1C, 32'h0000_0FF0, 4'd7},  // R7 set alias
      '{1'b1, 8'h60, 2'd2, 32'h0000_00A0, 8'h64, 32'h0000_0F50, 4'd7},  // R7 clear alias, alias read
      '{1'b1, 8'h84, 2'd2, 32'h0000_0001, 8'h20, 32'h0000_0001, 4'd7},  // R7 wake set
      '{1'b1, 8'h80, 2'd2, 32'h0000_0001, 8'h84, 32'h0000_0000, 4'd7},  // R7 wake clear
      '{1'b1, 8'h3C, 2'd2, 32'h1234_5678, 8'h3C, 32'h1234_5678, 4'd7},  // R7 data out
      '{1'b1, 8'h94, 2'd2, 32'h8000_0001, 8'h3C, 32'h9234_5679, 4'd7},  // R7 data set
      '{1'b1, 8'h90, 2'd2, 32'h0000_0070, 8'h90, 32'h9234_5609, 4'd7},  // R7 data clear
      '{1'b1, 8'h3D, 2'd0, 32'h0000_00AB, 8'h3C, 32'h9234_AB09, 4'd11}, // R11 byte merge
      '{1'b1, 8'h3E, 2'd1, 32'h0000_CDEF, 8'h3C, 32'hCDEF_AB09, 4'd11}, // R11 half merge
      '{1'b1, 8'h95, 2'd0, 32'h0000_0010, 8'h3C, 32'hCDEF_BB09, 4'd11}, // R11 byte alias
      '{1'b0, 8'h00, 2'd2, 32'h0,         8'h3E, 32'h0000_CDEF, 4'd11}, // R11 narrow read
      '{1'b0, 8'h00, 2'd2, 32'h0,         8'h3D, 32'h00CD_EFBB, 4'd11}, // R11 narrow read
      '{1'b1, 8'h30, 2'd2, 32'h0000_00FF, 8'h30, 32'h0000_0007, 4'd10}, // R10 control width
      '{1'b1, 8'h50, 2'd2, 32'hDEAD_BEEF, 8'h50, 32'hDEAD_BEEF, 4'd12}, // R12
      '{1'b1, 8'h54, 2'd2, 32'h0000_01FF, 8'h54, 32'h0000_00FF, 4'd12}, // R12
      '{1'b1, 8'h51, 2'd0, 32'h0000_0000, 8'h50, 32'hDEAD_00EF, 4'd11}, // R11 byte merge
      '{1'b1, 8'h00, 2'd2, 32'h0000_0055, 8'h00, 32'h0000_0031, 4'd1},  // R1 revision
      '{1'b1, 8'h14, 2'd2, 32'h0000_0000, 8'h14, 32'h0000_0001, 4'd1},  // R1 status word
      '{1'b0, 8'h00, 2'd2, 32'h0,         8'h58, 32'h0000_0000, 4'd1},  // R1 unknown
      '{1'b1, 8'h38, 2'd2, 32'h0000_FFFF, 8'h38, 32'h0000_0000, 4'd1}   // R1 data in
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic hard_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd("R1", 8'h34, 32'hFFFF_FFFF);
      rd("R1", 8'h30, 32'h0000_0002);
      rd("R1", 8'h18, 32'h0);
      rd("R1", 8'h28, 32'h0);
      rd("R1", 8'h1C, 32'h0);
      rd("R1", 8'h10, 32'h0);
      check("R4", {31'b0, irq_a}, 32'h0);
      check("R8", pin_drive, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (TBL[i].wr) wr(TBL[i].wa, TBL[i].sz, TBL[i].wd);
         rd($sformatf("R%0d", TBL[i].rq), TBL[i].ra, TBL[i].ex);
      end

      hard_reset();
      wr(8'h1C, 2'd2, 32'hFFFF_FFFF);
      wr(8'h48, 2'd2, 32'h0000_0001);
      wr(8'h4C, 2'd2, 32'h0000_0002);
      // R2 rising edge sets both sets
      pin_in[0] = 1'b1; settle();
      rd("R2", 8'h18, 32'h1);
      rd("R2", 8'h28, 32'h1);
      check("R4", {30'b0, irq_b, irq_a}, 32'h1);
      // R2 rise on a falling-only pin, then its fall
      pin_in[1] = 1'b1; settle();
      rd("R2", 8'h18, 32'h1);
      pin_in[1] = 1'b0; settle();
      rd("R2", 8'h18, 32'h3);
      // R5 clear A only; R4 irq_b follows enable B
      wr(8'h18, 2'd2, 32'h3);
      rd("R5", 8'h18, 32'h0);
      rd("R5", 8'h28, 32'h3);
      check("R4", {30'b0, irq_b, irq_a}, 32'h0);
      wr(8'h74, 2'd2, 32'h2);
      rd("R7", 8'h2C, 32'h2);
      check("R4", {30'b0, irq_b, irq_a}, 32'h2);
      // R3 output pin raises nothing
      wr(8'h34, 2'd2, 32'hFFFF_FFF7);
      wr(8'h48, 2'd2, 32'h0000_0009);
      pin_in[3] = 1'b1; settle();
      rd("R3", 8'h18, 32'h0);
      check("R8", pin_drive, 32'h8);
      // R5 level-high held through a clear
      wr(8'h44, 2'd2, 32'h10);
      rd("R5", 8'h18, 32'h0);
      pin_in[4] = 1'b1; settle();
      rd("R2", 8'h18, 32'h10);
      rd("R2", 8'h28, 32'h13);
      wr(8'h18, 2'd2, 32'h10);
      rd("R5", 8'h18, 32'h10);
      pin_in[4] = 1'b0; settle();
      wr(8'h18, 2'd2, 32'h10);
      rd("R5", 8'h18, 32'h0);
      // R6 level-low write, output-enable writes
      wr(8'h40, 2'd2, 32'h20);
      rd("R6", 8'h18, 32'h20);
      rd("R6", 8'h28, 32'h33);
      wr(8'h34, 2'd2, 32'hFFFF_FFD7);
      wr(8'h18, 2'd2, 32'h20);
      rd("R6", 8'h18, 32'h0);
      wr(8'h34, 2'd2, 32'hFFFF_FFF7);
      rd("R6", 8'h18, 32'h20);
      // R9 wake gating
      wr(8'h84, 2'd2, 32'h40);
      wr(8'h48, 2'd2, 32'h49);
      wr(8'h10, 2'd2, 32'h04);
      pin_in[6] = 1'b1; settle();
      rd("R2", 8'h18, 32'h60);
      check("R9", wake_cnt, 32'd0);
      wr(8'h10, 2'd2, 32'h0C);
      pin_in[6] = 1'b0; settle();
      pin_in[6] = 1'b1; settle();
      check("R9", wake_cnt, 32'd1);
      pin_in[0] = 1'b0; settle();
      pin_in[0] = 1'b1; settle();
      check("R9", wake_cnt, 32'd1);
      rd("R2", 8'h18, 32'h61);
      // R11 narrow status clears
      wr(8'h19, 2'd0, 32'hFF);
      rd("R11", 8'h18, 32'h61);
      wr(8'h18, 2'd0, 32'h40);
      rd("R11", 8'h18, 32'h21);
      // R10 soft reset
      wr(8'h3C, 2'd2, 32'hA5A5_A5A5);
      wr(8'h10, 2'd2, 32'hFF);
      rd("R10", 8'h10, 32'h1D);
      rd("R10", 8'h1C, 32'h0);
      rd("R10", 8'h18, 32'h0);
      rd("R10", 8'h34, 32'hFFFF_FFFF);
      rd("R10", 8'h30, 32'h2);
      rd("R10", 8'h20, 32'h0);
      rd("R10", 8'h3C, 32'hA5A5_A5A5);
      check("R10", {31'b0, irq_a}, 32'h0);
      // R8 pins
      wr(8'h34, 2'd2, 32'hFFFF_0000);
      check("R8", pin_drive, 32'h0000_FFFF);
      check("R8", pin_out, 32'h0000_A5A5);

      done = 1;
      finish_run();
   end
endmodule